// File: doc/BRIEF.md
# SPI Slave with Transmit Underrun Detection

This block is the slave end of a serial peripheral interface link. It exchanges characters of `DATA_W` bits (8 by default), most significant bit first, with an external master. The serial clock, the active-low select and the master-out data line come from off chip. They pass through two-flop synchronisers, and the block then samples them in the system clock domain. Edges of the serial clock are found by comparing the synchronised level with its value one cycle earlier. The polarity and the phase of the serial clock are set by two static configuration inputs.

On the host side there is a one-character transmit holding register, a one-character receive register and two sticky flags. A character slot opens when the slave commits to the next outgoing character. If the holding register is empty at that moment, the underrun flag is set and the slot sends all ones. A byte written later is sent in the following slot. If a received character completes while the previous one has not been read, the overrun flag is set. A single status-reset pulse clears both flags.

Top module: `spi_uflow_slave`

## Requirements
- R1: A slot opens only after the synchronised select has been low for `SETUP_CYC` consecutive system cycles. With `spi_cpha`=0, the slot opens as soon as that window has passed with the clock at its idle level. While select stays low, it opens again after the last trailing edge of each character. With `spi_cpha`=1, the slot opens on the first leading edge of each character.
- R2: If a slot opens while the holding register is empty (`tx_empty_o`=1), `unre_o` is set.
- R3: During an underrun slot, `miso_o` stays 1 for every bit, so the master reads 0xFF.
- R4: `thr_wr_i` loads `thr_data_i` and drives `tx_empty_o` to 0. The next slot consumes the byte, which drives `tx_empty_o` back to 1, and shifts it out MSB first. A byte written after an underrun is sent in the following slot.
- R5: `unre_o` and `ovre_o` are sticky. Both stay set until a one-cycle `rst_sta_i` pulse clears them both.
- R6: Received bits are assembled MSB first. After the last bit is sampled, `rx_data_o` holds the character and `rx_valid_o` is 1. `rx_rd_i` clears `rx_valid_o`.
- R7: If a character completes while `rx_valid_o` is 1 and no read occurs in that cycle, `ovre_o` is set and `rx_data_o` takes the new character.
- R8: If select rises before the last bit of a character, the character is dropped: `rx_valid_o` and `rx_data_o` keep their values. The next selection starts again at the first bit.
- R9: A leading edge is the clock moving away from the level `spi_cpol`. With `spi_cpha`=0, data is sampled on leading edges and shifted on trailing edges. With `spi_cpha`=1, data is shifted on leading edges and sampled on trailing edges. All four combinations work.
- R10: `miso_o` is 1 whenever no slot is shifting, including while the slave is deselected.
- R11: After reset, `tx_empty_o`=1, `rx_valid_o`=0, `unre_o`=0, `ovre_o`=0, `rx_data_o`=0 and `miso_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cpol | input | 1 | Idle level of the serial clock |
| spi_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_i | input | 1 | Active-low slave select (asynchronous) |
| mosi_i | input | 1 | Master-out serial data (asynchronous) |
| miso_o | output | 1 | Slave-out serial data |
| thr_wr_i | input | 1 | Write strobe for the transmit holding register |
| thr_data_i | input | DATA_W | Byte to transmit |
| rx_rd_i | input | 1 | Read strobe that consumes the received byte |
| rst_sta_i | input | 1 | Clears the underrun and overrun flags |
| rx_data_o | output | DATA_W | Last received character |
| rx_valid_o | output | 1 | Unread received character present |
| tx_empty_o | output | 1 | Transmit holding register empty |
| unre_o | output | 1 | Sticky transmit underrun flag |
| ovre_o | output | 1 | Sticky receive overrun flag |

## Verification
The bench uses the default parameters: `DATA_W`=8, `SYNC_STAGES`=2 and `SETUP_CYC`=16. It drives the serial clock with a half period of 8 system cycles, so one bit period matches the select setup window. Because that window is short, the bench can probe ten cycles after select falls and confirm that no slot has opened yet. The slow clock leaves several settled cycles after each edge, once the synchroniser and edge-detect latency has passed. The host-side flags are compared with a behavioural model in those cycles, in all four clock modes.

// File: rtl/spi_uflow_pkg.sv
package spi_uflow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_uflow_sync.sv
module spi_uflow_sync #(
    parameter int                STAGES  = 2,
    parameter int                WIDTH   = 1,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], async_d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_uflow_engine.sv
module spi_uflow_engine
    import spi_uflow_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              sck_s,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    input  logic              load_full,
    input  logic [DATA_W-1:0] load_data,
    output logic              slot_open,
    output logic              char_done,
    output logic [DATA_W-1:0] char_data,
    output logic              miso
);

    localparam int SET_W = $clog2(SETUP_CYC + 1);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [SET_W-1:0] SETUP_V  = SET_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        eng_state_e        st;
        logic              sck_prev;
        logic [SET_W-1:0]  sel_cnt;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-2:0] rx_sr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic toggled, lead, trail, setup_ok, sample_edge, shift_edge;
    logic [DATA_W-1:0] slot_word;

    always_comb begin
        toggled     = (sck_s != eng_q.sck_prev);
        lead        = toggled && (sck_s != cpol);
        trail       = toggled && (sck_s == cpol);
        setup_ok    = (eng_q.sel_cnt == SETUP_V);
        sample_edge = cpha ? trail : lead;
        shift_edge  = cpha ? lead : trail;
        slot_word   = load_full ? load_data : '1;
        char_data   = {eng_q.rx_sr, mosi_s};

        eng_d          = eng_q;
        eng_d.sck_prev = sck_s;
        slot_open      = 1'b0;
        char_done      = 1'b0;

        if (ss_n_s) begin
            eng_d.st      = ST_IDLE;
            eng_d.sel_cnt = '0;
            eng_d.bit_cnt = '0;
        end else begin
            if (!setup_ok) eng_d.sel_cnt = eng_q.sel_cnt + 1'b1;
            unique case (eng_q.st)
                ST_IDLE: begin
                    if (setup_ok && (sck_s == cpol)) begin
                        if (cpha) begin
                            eng_d.st = ST_ARMED;
                        end else begin
                            slot_open     = 1'b1;
                            eng_d.tx_sr   = slot_word;
                            eng_d.bit_cnt = '0;
                            eng_d.st      = ST_SHIFT;
                        end
                    end
                end
                ST_ARMED: begin
                    if (lead) begin
                        slot_open     = 1'b1;
                        eng_d.tx_sr   = slot_word;
                        eng_d.bit_cnt = '0;
                        eng_d.st      = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sample_edge) begin
                        eng_d.rx_sr = char_data[DATA_W-2:0];
                        if (eng_q.bit_cnt == LAST_BIT) begin
                            char_done     = 1'b1;
                            eng_d.bit_cnt = '0;
                            eng_d.st      = ST_IDLE;
                        end else begin
                            eng_d.bit_cnt = eng_q.bit_cnt + 1'b1;
                        end
                    end else if (shift_edge) begin
                        eng_d.tx_sr = {eng_q.tx_sr[DATA_W-2:0], 1'b1};
                    end
                end
                default: eng_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign miso = (eng_q.st == ST_SHIFT) ? eng_q.tx_sr[DATA_W-1] : 1'b1;

    assert_setup_before_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_open |-> (eng_q.sel_cnt == SETUP_V) && !ss_n_s);

    assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.bit_cnt <= LAST_BIT);

    assert_done_while_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |-> !ss_n_s && (eng_q.st == ST_SHIFT));

    assert_idle_line_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ss_n_s) && ss_n_s |-> miso);

endmodule

// File: rtl/spi_uflow_hostregs.sv
module spi_uflow_hostregs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_wdata,
    input  logic              rx_rd,
    input  logic              rst_sta,
    input  logic              slot_open,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    output logic              load_full,
    output logic [DATA_W-1:0] load_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              unre,
    output logic              ovre
);

    typedef struct packed {
        logic              thr_full;
        logic [DATA_W-1:0] thr_data;
        logic              rx_valid;
        logic [DATA_W-1:0] rx_data;
        logic              unre;
        logic              ovre;
    } host_t;

    host_t host_d, host_q;

    always_comb begin
        host_d = host_q;
        if (rst_sta) begin
            host_d.unre = 1'b0;
            host_d.ovre = 1'b0;
        end
        if (slot_open) begin
            if (host_q.thr_full) host_d.thr_full = 1'b0;
            else                 host_d.unre     = 1'b1;
        end
        if (thr_wr) begin
            host_d.thr_full = 1'b1;
            host_d.thr_data = thr_wdata;
        end
        if (rx_rd) host_d.rx_valid = 1'b0;
        if (char_done) begin
            host_d.rx_data  = char_data;
            host_d.rx_valid = 1'b1;
            if (host_q.rx_valid && !rx_rd) host_d.ovre = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_q <= '0;
        else        host_q <= host_d;
    end

    assign load_full = host_q.thr_full;
    assign load_data = host_q.thr_data;
    assign rx_valid  = host_q.rx_valid;
    assign rx_data   = host_q.rx_data;
    assign unre      = host_q.unre;
    assign ovre      = host_q.ovre;

    assert_unre_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_open && !host_q.thr_full |=> host_q.unre);

    assert_slot_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_open && host_q.thr_full && !thr_wr |=> !host_q.thr_full);

    assert_flags_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sta && !slot_open && !char_done |=> !host_q.unre && !host_q.ovre);

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && host_q.rx_valid && !rx_rd |=> host_q.ovre && host_q.rx_valid);

endmodule

// File: rtl/spi_uflow_slave.sv
module spi_uflow_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cpol,
    input  logic              spi_cpha,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              thr_wr_i,
    input  logic [DATA_W-1:0] thr_data_i,
    input  logic              rx_rd_i,
    input  logic              rst_sta_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              tx_empty_o,
    output logic              unre_o,
    output logic              ovre_o
);

    logic [2:0]        pins_s;
    logic              slot_open, char_done, load_full;
    logic [DATA_W-1:0] char_data, load_data;

    spi_uflow_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d ({ss_n_i, sck_i, mosi_i}),
        .sync_q  (pins_s)
    );

    spi_uflow_engine #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (spi_cpol),
        .cpha      (spi_cpha),
        .sck_s     (pins_s[1]),
        .ss_n_s    (pins_s[2]),
        .mosi_s    (pins_s[0]),
        .load_full (load_full),
        .load_data (load_data),
        .slot_open (slot_open),
        .char_done (char_done),
        .char_data (char_data),
        .miso      (miso_o)
    );

    spi_uflow_hostregs #(
        .DATA_W (DATA_W)
    ) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (thr_wr_i),
        .thr_wdata (thr_data_i),
        .rx_rd     (rx_rd_i),
        .rst_sta   (rst_sta_i),
        .slot_open (slot_open),
        .char_done (char_done),
        .char_data (char_data),
        .load_full (load_full),
        .load_data (load_data),
        .rx_valid  (rx_valid_o),
        .rx_data   (rx_data_o),
        .unre      (unre_o),
        .ovre      (ovre_o)
    );

    assign tx_empty_o = !load_full;

endmodule

// File: tb/spi_uflow_slave_test.sv
`timescale 1ns/1ps
module spi_uflow_slave_test;

    localparam int HB = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, cpol = 1'b0, cpha = 1'b0, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic thr_wr = 1'b0, rx_rd = 1'b0, rst_sta = 1'b0;
    logic [7:0] thr_data = 8'h00;
    logic miso, rx_valid, tx_empty, unre, ovre;
    logic [7:0] rx_data;

    spi_uflow_slave #(.DATA_W(8), .SYNC_STAGES(2), .SETUP_CYC(16)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cpol(cpol), .spi_cpha(cpha),
        .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi), .miso_o(miso),
        .thr_wr_i(thr_wr), .thr_data_i(thr_data), .rx_rd_i(rx_rd), .rst_sta_i(rst_sta),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_empty_o(tx_empty),
        .unre_o(unre), .ovre_o(ovre)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit cmp_en = 1'b0, done = 1'b0;

    bit m_thr_full = 1'b0, m_rxv = 1'b0, m_unre = 1'b0, m_ovre = 1'b0;
    logic [7:0] m_thr_q = 8'h00, m_rxd = 8'h00, m_cur = 8'hFF;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_slot();
        if (m_thr_full) begin
            m_cur = m_thr_q;
            m_thr_full = 1'b0;
        end else begin
            m_cur = 8'hFF;
            m_unre = 1'b1;
        end
    endtask

    task automatic model_done(input logic [7:0] b);
        if (m_rxv) m_ovre = 1'b1;
        m_rxv = 1'b1;
        m_rxd = b;
    endtask

    always @(posedge clk) begin
        #1;
        if (cmp_en && !done) begin
            chk("R2", "unre_o", unre, m_unre);
            chk("R7", "ovre_o", ovre, m_ovre);
            chk("R4", "tx_empty_o", tx_empty, !m_thr_full);
            chk("R6", "rx_valid_o", rx_valid, m_rxv);
            chk("R6", "rx_data_o", rx_data, m_rxd);
            if (ss_n) chk("R10", "miso_o deselected", miso, 1'b1);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000 && !done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        thr_wr = 1'b1; thr_data = b;
        m_thr_full = 1'b1; m_thr_q = b;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        rx_rd = 1'b1; m_rxv = 1'b0;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic status_reset();
        @(negedge clk);
        rst_sta = 1'b1; m_unre = 1'b0; m_ovre = 1'b0;
        @(negedge clk);
        rst_sta = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        @(negedge clk);
        cmp_en = 1'b0;
        cpol = pol; cpha = pha; sck = pol;
        repeat (6) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic sel_low();
        @(negedge clk);
        cmp_en = 1'b0;
        ss_n = 1'b0;
        repeat (10) @(negedge clk);
        if (!cpha) chk("R1", "tx_empty_o inside setup window", tx_empty, !m_thr_full);
        repeat (16) @(negedge clk);
        if (!cpha) model_slot();
        cmp_en = 1'b1;
    endtask

    task automatic sel_high();
        @(negedge clk);
        cmp_en = 1'b0;
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic xfer(input logic [7:0] mo, input int nbits, input string tag);
        logic [7:0] mi;
        logic [7:0] exp_tx;
        @(negedge clk);
        cmp_en = 1'b0;
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi = mo[7-i];
                repeat (HB) @(negedge clk);
                mi = {mi[6:0], miso};
                sck = ~cpol;
                repeat (HB) @(negedge clk);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mo[7-i];
                repeat (HB) @(negedge clk);
                mi = {mi[6:0], miso};
                sck = cpol;
                repeat (HB) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        if (cpha && nbits > 0) model_slot();
        exp_tx = m_cur;
        if (nbits == 8) begin
            chk(tag, "byte seen on miso", mi, exp_tx);
            model_done(mo);
            if (!cpha) model_slot();
        end
        cmp_en = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "tx_empty_o after reset", tx_empty, 1'b1);
        chk("R11", "rx_valid_o after reset", rx_valid, 1'b0);
        chk("R11", "unre_o after reset", unre, 1'b0);
        chk("R11", "ovre_o after reset", ovre, 1'b0);
        chk("R11", "rx_data_o after reset", rx_data, 8'h00);
        chk("R10", "miso_o after reset", miso, 1'b1);
        cmp_en = 1'b1;

        // R9 mode cpol=0 cpha=1, normal, underrun and recovery
        set_mode(1'b0, 1'b1);
        host_write(8'hA5);
        sel_low();
        xfer(8'h3C, 8, "R4");
        host_read();
        xfer(8'hC7, 8, "R3");
        chk("R2", "unre_o after empty slot", unre, 1'b1);
        host_write(8'h5A);
        xfer(8'hE1, 8, "R4");
        chk("R5", "unre_o still sticky", unre, 1'b1);
        status_reset();
        repeat (2) @(negedge clk);
        chk("R5", "unre_o cleared", unre, 1'b0);
        chk("R5", "ovre_o cleared", ovre, 1'b0);
        host_write(8'h99);
        xfer(8'h12, 8, "R4");
        chk("R7", "ovre_o after unread byte", ovre, 1'b1);
        chk("R7", "rx_data_o holds newest", rx_data, 8'h12);
        sel_high();
        host_read();

        // R8 abort mid character, then a clean character
        host_write(8'h11);
        sel_low();
        xfer(8'h0F, 4, "R8");
        sel_high();
        chk("R8", "rx_valid_o after abort", rx_valid, 1'b0);
        chk("R8", "rx_data_o after abort", rx_data, 8'h12);
        host_write(8'h22);
        sel_low();
        xfer(8'h81, 8, "R8");
        chk("R8", "rx_data_o after fresh start", rx_data, 8'h81);
        sel_high();
        host_read();

        // R9 mode cpol=1 cpha=0, including slot reopen at character end
        status_reset();
        set_mode(1'b1, 1'b0);
        host_write(8'hC3);
        sel_low();
        xfer(8'h96, 8, "R9");
        chk("R2", "unre_o after reopened empty slot", unre, 1'b1);
        host_write(8'h4B);
        host_read();
        xfer(8'h2D, 8, "R3");
        chk("R4", "tx_empty_o after reopen consumed write", tx_empty, 1'b1);
        sel_high();
        host_read();

        // R9 mode cpol=1 cpha=1
        status_reset();
        set_mode(1'b1, 1'b1);
        host_write(8'h6E);
        sel_low();
        xfer(8'hB4, 8, "R9");
        sel_high();
        host_read();

        // R9 mode cpol=0 cpha=0
        set_mode(1'b0, 1'b0);
        host_write(8'hF0);
        sel_low();
        xfer(8'h0A, 8, "R9");
        chk("R6", "rx_data_o mode 0", rx_data, 8'h0A);
        sel_high();
        host_read();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule